// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block takes one 24-bit left sample and one 24-bit right sample per audio frame from an upstream filter stage. It sends both on a single serial data line, most significant bit first. A bit clock and a left/right alignment clock go with the data line. Four framing formats are available: left-justified, right-justified, I2S and a DSP-style frame with a short sync pulse. The block reads the format, the clock-ownership mode and the rate class from static inputs. These inputs are only changed while reset is asserted.

In master mode the block divides its own clock, which is the master clock, down to a bit clock. There are 64 bit clocks per frame and 32 slots per channel. The divide ratio is 4 in single and dual rate operation (256 times the sample rate) and 3 in quad rate (192 times the sample rate). In slave mode the bit clock and alignment clock come from outside. The block passes them through synchroniser stages, detects their edges and shifts data out against them. In both modes the data line and the alignment clock change only on a falling bit-clock edge. A new sample pair is captured at each frame start.

Top module: `aud_tx_serializer`

## Requirements
- R1: While reset is asserted, `dout`, `bclkOut` and `lrclkOut` are all 0.
- R2: With `masterMode`=1, both clock output enables are 1. With `masterMode`=0, both enables are 0, and `bclkOut` and `lrclkOut` stay 0.
- R3: In master mode, successive falling edges of `bclkOut` are 4 clock cycles apart when `quadRate`=0 and 3 cycles apart when `quadRate`=1. A frame holds 64 bit-clock periods, slots 0..63, and slot 0 begins at the first falling edge after reset.
- R4: In master mode, `dout` and `lrclkOut` change only in the cycle where `bclkOut` falls.
- R5: Left-justified (`fmtSel`=0): `lrclkOut` is 1 for slots 0..31 (left) and 0 for slots 32..63. The left MSB is in slot 0 and the right MSB is in slot 32. Each word takes 24 consecutive slots and all other slots are 0.
- R6: I2S (`fmtSel`=2): `lrclkOut` is 0 for slots 0..31 (left) and 1 for slots 32..63. Each MSB comes one slot after the alignment edge, so the left MSB is in slot 1 and the right MSB is in slot 33. Unused slots are 0.
- R7: Right-justified (`fmtSel`=1): `lrclkOut` is the same as in left-justified. Each word ends with its LSB in the last slot of its half (slots 31 and 63), so the MSBs are in slots 8 and 40. Unused slots are 0.
- R8: DSP (`fmtSel`=3): `lrclkOut` is 1 in slot 0 only. The left word fills slots 1..24 and the right word follows at once in slots 25..48. Slots 0 and 49..63 are 0.
- R9: Both samples are captured at the start of a frame. A change on `leftSample` or `rightSample` during a frame appears only from the next frame on.
- R10: Slave mode: every falling edge of `bclkIn` advances one slot. Slot 0 restarts on the alignment edge that opens the left channel: a rising edge of `lrclkIn`, or a falling edge in I2S. `dout` carries the same slot pattern as in R5..R8 and settles within 4 clock cycles after the falling edge of `bclkIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every register runs on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = block drives the clocks, 0 = block follows external clocks |
| quadRate | input | 1 | 1 = quad-rate divide of 3, 0 = divide of 4 |
| fmtSel | input | 2 | 0 left-justified, 1 right-justified, 2 I2S, 3 DSP |
| leftSample | input | 24 | Left-channel sample word |
| rightSample | input | 24 | Right-channel sample word |
| bclkIn | input | 1 | External bit clock (slave mode) |
| lrclkIn | input | 1 | External alignment clock (slave mode) |
| dout | output | 1 | Serial data line |
| bclkOut | output | 1 | Generated bit clock (master mode) |
| lrclkOut | output | 1 | Generated alignment clock (master mode) |
| bclkOe | output | 1 | Output enable for the bit clock pin |
| lrclkOe | output | 1 | Output enable for the alignment clock pin |

## Verification
The case that is hardest to reach from the ports is a sample word changing while the serializer is partway through the word it replaces. This only shows up if the stimulus changes the input exactly at a known slot inside a running frame. The bench counts falling bit-clock edges itself, writes a new left sample right after slot 5 of a frame, and then expects the old word for the rest of that frame and the new word in the following frame. It does this in master mode and also in slave mode. In slave mode the bench is the clock source, so it knows each slot number exactly, and the edge detector sees the new value only after the synchroniser delay.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int SAMPLE_W = 24;
  localparam int SLOT_W   = 6;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'd0,
    FMT_RIGHT = 2'd1,
    FMT_I2S   = 2'd2,
    FMT_DSP   = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              bitTick;
    logic              frameStart;
    logic [SLOT_W-1:0] slot;
  } txStrobe_t;
endpackage

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
#(
  parameter int DIV_STD     = 4,
  parameter int DIV_QUAD    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      masterMode,
  input  logic      quadRate,
  input  fmt_e      fmt,
  input  logic      bclkIn,
  input  logic      lrclkIn,
  output logic      bclkGen,
  output txStrobe_t strb
);
  localparam int DIV_MAX = (DIV_STD > DIV_QUAD) ? DIV_STD : DIV_QUAD;
  localparam int DIV_W   = $clog2(DIV_MAX) + 1;

  // input synchronisers for the external clocks
  logic [SYNC_STAGES-1:0] bSync, lSync;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
    end else begin
      bSync <= {bSync[SYNC_STAGES-2:0], bclkIn};
      lSync <= {lSync[SYNC_STAGES-2:0], lrclkIn};
    end
  end

  logic bLast, lrPrev, armed;
  logic lrNow, startLevel, lrEdge, slaveFall, slaveStart;
  assign lrNow      = lSync[SYNC_STAGES-1];
  assign startLevel = (fmt != FMT_I2S);
  assign lrEdge     = (lrNow != lrPrev) && (lrNow == startLevel);
  assign slaveFall  = bLast && !bSync[SYNC_STAGES-1];
  assign slaveStart = slaveFall && (armed || lrEdge);

  // master-mode bit clock divider
  logic [DIV_W-1:0] divCnt, divNext, divLast, divLen, divHi;
  logic masterTick;
  assign divLast    = quadRate ? DIV_W'(DIV_QUAD - 1) : DIV_W'(DIV_STD - 1);
  assign divLen     = divLast + 1'b1;
  assign divHi      = divLen - (divLen >> 1);
  assign masterTick = masterMode && (divCnt == divLast);
  assign divNext    = (!masterMode || masterTick) ? '0 : divCnt + 1'b1;

  logic tick;
  logic [SLOT_W-1:0] slotQ, nextSlot;
  assign tick     = masterMode ? masterTick : slaveFall;
  assign nextSlot = (!masterMode && slaveStart) ? '0 : slotQ + 1'b1;

  always_comb begin
    strb.bitTick    = tick;
    strb.frameStart = tick && (nextSlot == '0);
    strb.slot       = nextSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt  <= '0;
      bclkGen <= 1'b0;
      slotQ   <= '1;
      bLast   <= 1'b0;
      lrPrev  <= 1'b0;
      armed   <= 1'b0;
    end else begin
      divCnt  <= divNext;
      bclkGen <= masterMode && (divNext >= divHi);
      bLast   <= bSync[SYNC_STAGES-1];
      lrPrev  <= lrNow;
      if (tick) slotQ <= nextSlot;
      if (slaveFall)   armed <= 1'b0;
      else if (lrEdge) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_tx_dpath.sv
module aud_tx_dpath
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = SAMPLE_W,
  parameter int SLOTS_W = SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fmt_e              fmt,
  input  logic [WORD_W-1:0] leftSample,
  input  logic [WORD_W-1:0] rightSample,
  input  txStrobe_t         strb,
  output logic              doutQ,
  output logic              lrQ
);
  localparam int HALF = 2 ** (SLOTS_W - 1);
  localparam int PAD  = HALF - WORD_W;

  logic [WORD_W-1:0] shL, shR, word, shifted;
  int si, pos, idx;
  logic useRight, valid, lrNext, bitNext;

  always_comb begin
    si       = int'(strb.slot);
    pos      = si % HALF;
    useRight = (si >= HALF);
    valid    = 1'b0;
    idx      = 0;
    lrNext   = 1'b0;
    case (fmt)
      FMT_LEFT: begin
        valid  = (pos < WORD_W);
        idx    = pos;
        lrNext = !useRight;
      end
      FMT_RIGHT: begin
        valid  = (pos >= PAD);
        idx    = pos - PAD;
        lrNext = !useRight;
      end
      FMT_I2S: begin
        valid  = (pos >= 1) && (pos <= WORD_W);
        idx    = pos - 1;
        lrNext = useRight;
      end
      default: begin
        useRight = (si > WORD_W);
        valid    = (si >= 1) && (si <= 2 * WORD_W);
        idx      = useRight ? si - 1 - WORD_W : si - 1;
        lrNext   = (si == 0);
      end
    endcase
    if (!valid) idx = 0;
    if (useRight) word = strb.frameStart ? rightSample : shR;
    else          word = strb.frameStart ? leftSample  : shL;
    shifted = word << idx;
    bitNext = valid && shifted[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shL   <= '0;
      shR   <= '0;
      doutQ <= 1'b0;
      lrQ   <= 1'b0;
    end else if (strb.bitTick) begin
      doutQ <= bitNext;
      lrQ   <= lrNext;
      if (strb.frameStart) begin
        shL <= leftSample;
        shR <= rightSample;
      end
    end
  end
endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
  import aud_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterMode,
  input  logic                quadRate,
  input  logic [1:0]          fmtSel,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  output logic                dout,
  output logic                bclkOut,
  output logic                lrclkOut,
  output logic                bclkOe,
  output logic                lrclkOe
);
  txStrobe_t strb;
  logic bclkGen, lrQ;
  fmt_e fmt;
  assign fmt = fmt_e'(fmtSel);

  aud_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .quadRate(quadRate),
    .fmt(fmt), .bclkIn(bclkIn), .lrclkIn(lrclkIn),
    .bclkGen(bclkGen), .strb(strb)
  );

  aud_tx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .fmt(fmt),
    .leftSample(leftSample), .rightSample(rightSample),
    .strb(strb), .doutQ(dout), .lrQ(lrQ)
  );

  assign bclkOut  = bclkGen;
  assign lrclkOut = masterMode && lrQ;
  assign bclkOe   = masterMode;
  assign lrclkOe  = masterMode;
endmodule

// File: rtl/aud_tx_checker.sv
module aud_tx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       masterMode,
  input logic       quadRate,
  input logic [1:0] fmtSel,
  input logic       dout,
  input logic       bclkOut,
  input logic       lrclkOut
);
  logic bclkQ, seenFall, fallNow;
  logic [3:0] gapCnt;
  assign fallNow = bclkQ && !bclkOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkQ    <= 1'b0;
      seenFall <= 1'b0;
      gapCnt   <= '0;
    end else begin
      bclkQ <= bclkOut;
      if (fallNow) begin
        seenFall <= 1'b1;
        gapCnt   <= 4'd1;
      end else if (gapCnt != 4'd15) begin
        gapCnt <= gapCnt + 4'd1;
      end
    end
  end

  p_bclk_period_r3: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && seenFall && fallNow) |-> (gapCnt == (quadRate ? 4'd3 : 4'd4)));

  p_change_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !fallNow) |-> ($stable(dout) && $stable(lrclkOut)));

  p_dsp_pulse_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && fmtSel == 2'd3 && lrclkOut) |-> !dout);

  p_i2s_edge_slot_r6: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && fmtSel == 2'd2 && fallNow && (lrclkOut != $past(lrclkOut))) |-> !dout);

  p_slave_pins_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !masterMode |-> (!bclkOut && !lrclkOut));
endmodule

bind aud_tx_serializer aud_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .masterMode(masterMode), .quadRate(quadRate),
  .fmtSel(fmtSel), .dout(dout), .bclkOut(bclkOut), .lrclkOut(lrclkOut)
);

// File: tb/aud_tx_serializer_bench.sv
module aud_tx_serializer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterMode = 1'b1;
  logic quadRate = 1'b0;
  logic [1:0] fmtSel = 2'd0;
  logic [23:0] leftSample = '0;
  logic [23:0] rightSample = '0;
  logic bclkIn = 1'b1;
  logic lrclkIn = 1'b0;
  logic dout, bclkOut, lrclkOut, bclkOe, lrclkOe;

  always #5 clk = ~clk;

  aud_tx_serializer u_aud_tx_serializer (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .quadRate(quadRate),
    .fmtSel(fmtSel), .leftSample(leftSample), .rightSample(rightSample),
    .bclkIn(bclkIn), .lrclkIn(lrclkIn), .dout(dout), .bclkOut(bclkOut),
    .lrclkOut(lrclkOut), .bclkOe(bclkOe), .lrclkOe(lrclkOe)
  );

  int tests = 0;
  int fails = 0;
  logic prevB;
  bit skipGap;

  typedef struct packed {
    logic [1:0]  f;
    logic        q;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 24'hA5C3F1, 24'h3C5A0F},
    '{2'd1, 1'b0, 24'h800001, 24'hFFFFFE},
    '{2'd2, 1'b1, 24'h123456, 24'hFEDCBA},
    '{2'd3, 1'b0, 24'hC00003, 24'h7FFFFF},
    '{2'd3, 1'b1, 24'h5AA5C3, 24'h00F00F},
    '{2'd2, 1'b0, 24'hFFFFFF, 24'h000001}
  };

  function automatic logic refBit(int f, int s, logic [23:0] L, logic [23:0] R);
    case (f)
      0: begin
        if (s < 24) return L[23 - s];
        if (s >= 32 && s < 56) return R[55 - s];
      end
      1: begin
        if (s >= 8 && s < 32) return L[31 - s];
        if (s >= 40) return R[63 - s];
      end
      2: begin
        if (s >= 1 && s <= 24) return L[24 - s];
        if (s >= 33 && s <= 56) return R[56 - s];
      end
      default: begin
        if (s >= 1 && s <= 24) return L[24 - s];
        if (s >= 25 && s <= 48) return R[48 - s];
      end
    endcase
    return 1'b0;
  endfunction

  function automatic logic refLr(int f, int s);
    case (f)
      0, 1: return s < 32;
      2: return s >= 32;
      default: return s == 0;
    endcase
  endfunction

  function automatic string reqOf(int f);
    case (f)
      0: return "R5";
      1: return "R7";
      2: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(bit m, int f, bit q, logic [23:0] L, logic [23:0] R);
    @(negedge clk);
    rstN = 1'b0;
    masterMode = m;
    quadRate = q;
    fmtSel = f[1:0];
    leftSample = L;
    rightSample = R;
    bclkIn = 1'b1;
    lrclkIn = refLr(f, 63);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    prevB = bclkOut;
    skipGap = 1'b1;
    if (!m) repeat (4) @(negedge clk);
  endtask

  task automatic runFrame(bit m, int f, int expDiv, logic [23:0] eL, logic [23:0] eR,
                          int chgSlot, logic [23:0] newL,
                          output int errD, output int errL, output int errP);
    int cyc;
    errD = 0; errL = 0; errP = 0;
    for (int s = 0; s < 64; s++) begin
      if (m) begin
        cyc = 0;
        forever begin
          @(negedge clk);
          cyc++;
          if (prevB && !bclkOut) begin
            prevB = bclkOut;
            break;
          end
          prevB = bclkOut;
        end
        if (!skipGap && cyc != expDiv) errP++;
        skipGap = 1'b0;
        if (lrclkOut !== refLr(f, s)) errL++;
      end else begin
        @(negedge clk);
        bclkIn = 1'b0;
        lrclkIn = refLr(f, s);
        repeat (3) @(negedge clk);
        bclkIn = 1'b1;
        repeat (4) @(negedge clk);
      end
      if (dout !== refBit(f, s, eL, eR)) errD++;
      if (s == chgSlot) leftSample = newL;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int eD, eL, eP;
    // R1 / R2: reset state, master configuration
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(dout === 1'b0, "R1", "dout in reset", int'(dout), 0);
    chk(bclkOut === 1'b0, "R1", "bclkOut in reset", int'(bclkOut), 0);
    chk(lrclkOut === 1'b0, "R1", "lrclkOut in reset", int'(lrclkOut), 0);
    chk(bclkOe === 1'b1 && lrclkOe === 1'b1, "R2", "master enables", int'({bclkOe, lrclkOe}), 3);

    // vector table: master mode, each format and rate class, two frames
    foreach (VECS[i]) begin
      doReset(1'b1, int'(VECS[i].f), VECS[i].q, VECS[i].l, VECS[i].r);
      for (int fr = 0; fr < 2; fr++) begin
        runFrame(1'b1, int'(VECS[i].f), VECS[i].q ? 3 : 4, VECS[i].l, VECS[i].r, -1, '0, eD, eL, eP);
        chk(eD == 0, reqOf(int'(VECS[i].f)), "dout slot errors", eD, 0);
        chk(eL == 0, reqOf(int'(VECS[i].f)), "lrclk slot errors", eL, 0);
        chk(eP == 0, "R3", "bit clock gap errors", eP, 0);
      end
    end

    // R9: mid-frame sample change in master mode
    doReset(1'b1, 0, 1'b0, 24'h0F0F0F, 24'h333333);
    runFrame(1'b1, 0, 4, 24'h0F0F0F, 24'h333333, 5, 24'hF0F0F0, eD, eL, eP);
    chk(eD == 0, "R9", "master frame keeps old word", eD, 0);
    runFrame(1'b1, 0, 4, 24'hF0F0F0, 24'h333333, -1, '0, eD, eL, eP);
    chk(eD == 0, "R9", "master next frame new word", eD, 0);

    // R2 / R10: slave mode, each format
    for (int f = 0; f < 4; f++) begin
      doReset(1'b0, f, 1'b0, 24'h9A5F31 ^ 24'(f), 24'h6C0E97);
      chk(bclkOe === 1'b0 && lrclkOe === 1'b0, "R2", "slave enables", int'({bclkOe, lrclkOe}), 0);
      for (int fr = 0; fr < 2; fr++) begin
        runFrame(1'b0, f, 8, 24'h9A5F31 ^ 24'(f), 24'h6C0E97, -1, '0, eD, eL, eP);
        chk(eD == 0, "R10", "slave dout slot errors", eD, 0);
        chk(bclkOut === 1'b0 && lrclkOut === 1'b0, "R2", "slave clock outputs low",
            int'({bclkOut, lrclkOut}), 0);
      end
    end

    // R9 / R10: mid-frame sample change in slave I2S
    doReset(1'b0, 2, 1'b0, 24'hABCDEF, 24'h13579B);
    runFrame(1'b0, 2, 8, 24'hABCDEF, 24'h13579B, 5, 24'h2468AC, eD, eL, eP);
    chk(eD == 0, "R9", "slave frame keeps old word", eD, 0);
    runFrame(1'b0, 2, 8, 24'h2468AC, 24'h13579B, -1, '0, eD, eL, eP);
    chk(eD == 0, "R9", "slave next frame new word", eD, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule